// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs one DMA channel through a single job. It holds the remaining transfer count, a chain count with a reload value for chained blocks, the destination address and a sticky end-of-transfer flag. Requests can come from three places: a level request from an on-chip peripheral, an external request whose rising edge is captured, or a permanent internal request. The channel raises a transfer request toward the bus side while it has work to do and a request is pending. The bus side then pulses a completion strobe in the last bus cycle of each transfer.

Each completion steps the destination address by the programmed mode and unit size and counts the transfer down. At the end of a block, the channel either reloads from the chain registers and carries on, or sets the end flag. One selectable rule decides whether the end flag is set after every block or only after the last chained block. The channel also times a one-cycle clear pulse back to the on-chip requester. Software programs the channel through a plain write port.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, the transfer count, chain count, destination address and end flag are 0, and `xfer_req`, `flag_clr` and `irq` are low. The control word is 0, which selects the on-chip source, fixed destination, clear-at-end timing and end-after-all-chains.
- R2: When `end_sel` (control bit 5) is 1, the end flag is set on the completion that brings the transfer count from 1 to 0, whatever the chain count. The same applies when the source field is 2 (internal request), whatever the value of `end_sel`.
- R3: When `end_sel` is 0 and the source is not 2, the count reaching 0 sets the end flag only if the chain count is 0. With chaining disabled and a nonzero chain count, the count stays at 0 and the end flag stays clear.
- R4: On each counted completion, the destination mode (control bits 2:1) decides the address change: 00 leaves it fixed, 01 adds the step, 10 subtracts the step, and 11 acts as fixed. The unit size (control bits 4:3) sets the step: 0 gives 1, 1 gives 2, and 2 or 3 gives 4.
- R5: When the single-address-to-device bit (control bit 10) is 1, the destination address never changes on completions, whatever the mode.
- R6: `irq` is high exactly while both the end flag and the interrupt enable (control bit 0) are 1.
- R7: With the on-chip source (source field 0), `flag_clr` is high during the completion cycle in either of two cases. With `clr_sel` (control bit 6) at 1, it is high on every counted completion. With `clr_sel` at 0, it is high only on the completion that takes the count from 1 to 0.
- R8: With the external source (source field 1), a rising edge of `ext_req` latches a pending request. The pending request is dropped on every counted completion when `clr_sel` is 1, and only on the completion that empties the count when `clr_sel` is 0.
- R9: When chaining is enabled (control bit 7), the count goes from 1 to 0 and the chain count is nonzero, the chain count decrements and the transfer count reloads from the reload register on the same edge.
- R10: The end flag is sticky. While it is set, completions change nothing and `xfer_req` is low. Only a control write with bit 11 equal to 0 clears it, and writing 1 to bit 11 leaves it unchanged.
- R11: `xfer_req` is high when the count is nonzero, the end flag is clear and the selected source has a request. That request is `mod_req` for source 0, the latched edge for source 1, always present for source 2, and never present for source 3.
- R12: A write takes effect on the next clock edge, selected by `wr_sel`: 0 control, 1 destination address, 2 transfer count, 3 reload value, 4 chain count. A write overrides any completion update to the same register in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | AW | Write data |
| mod_req | input | 1 | Level request from on-chip peripheral |
| ext_req | input | 1 | External request, edge captured |
| xfer_done | input | 1 | Last bus cycle of a transfer |
| xfer_req | output | 1 | Transfer request to bus side |
| flag_clr | output | 1 | Clear pulse to on-chip requester |
| dst_addr | output | AW | Destination address |
| xfer_cnt | output | CW | Remaining transfer count |
| chain_cnt | output | NW | Remaining chain count |
| end_flag | output | 1 | Sticky transfer-end flag |
| irq | output | 1 | End-of-transfer interrupt request |

## Verification
`flag_clr` is combinational in the completion cycle, so the bench reads it 1 ns after it raises `xfer_done`, before the clock edge. Address, count, chain count and the end flag are registered, and `irq` follows the end flag with no delay. The bench samples all of these at the falling edge after the completion edge. A latched external edge shows on `xfer_req` one edge after `ext_req` rises, so that check waits exactly one clock.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          mod_req,
  input  logic          ext_req,
  input  logic          xfer_done,
  output logic          xfer_req,
  output logic          flag_clr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] xfer_cnt,
  output logic [NW-1:0] chain_cnt,
  output logic          end_flag,
  output logic          irq
);
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_ADDR = 3'd1, SEL_CNT = 3'd2,
                         SEL_RLD = 3'd3, SEL_CHN = 3'd4;
  localparam logic [1:0] SRC_MOD = 2'd0, SRC_EXT = 2'd1, SRC_AUTO = 2'd2;

  logic [10:0]   ctrl;
  logic [CW-1:0] reload;
  logic          ext_prev, ext_pend;

  wire       irq_en     = ctrl[0];
  wire [1:0] dmode      = ctrl[2:1];
  wire [1:0] usz        = ctrl[4:3];
  wire       end_sel    = ctrl[5];
  wire       clr_sel    = ctrl[6];
  wire       chain_en   = ctrl[7];
  wire [1:0] src        = ctrl[9:8];
  wire       single_dev = ctrl[10];

  wire [AW-1:0] step = (usz == 2'd0) ? AW'(1) : (usz == 2'd1) ? AW'(2) : AW'(4);

  wire active    = (xfer_cnt != '0) && !end_flag;
  wire beat      = xfer_done && active;
  wire last      = beat && (xfer_cnt == CW'(1));
  wire chain_go  = last && chain_en && (chain_cnt != '0);
  wire end_by_tc = end_sel || (src == SRC_AUTO);
  wire set_end   = last && (end_by_tc || (!chain_go && chain_cnt == '0));
  wire clr_now   = beat && (clr_sel || xfer_cnt == CW'(1));

  logic pending;
  always_comb begin
    case (src)
      SRC_MOD:  pending = mod_req;
      SRC_EXT:  pending = ext_pend;
      SRC_AUTO: pending = 1'b1;
      default:  pending = 1'b0;
    endcase
  end

  assign xfer_req = active && pending;
  assign flag_clr = clr_now && (src == SRC_MOD);
  assign irq      = end_flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      ext_pend <= 1'b0;
    end else begin
      ext_prev <= ext_req;
      if (ext_req && !ext_prev)
        ext_pend <= 1'b1;
      else if (clr_now && src == SRC_EXT)
        ext_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      reload    <= '0;
      dst_addr  <= '0;
      xfer_cnt  <= '0;
      chain_cnt <= '0;
      end_flag  <= 1'b0;
    end else begin
      if (beat) begin
        xfer_cnt <= chain_go ? reload : xfer_cnt - CW'(1);
        if (chain_go) chain_cnt <= chain_cnt - NW'(1);
        if (set_end) end_flag <= 1'b1;
        if (!single_dev) begin
          if (dmode == 2'b01) dst_addr <= dst_addr + step;
          else if (dmode == 2'b10) dst_addr <= dst_addr - step;
        end
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_CTRL: begin
            ctrl <= wr_data[10:0];
            if (!wr_data[11]) end_flag <= 1'b0;
          end
          SEL_ADDR: dst_addr  <= wr_data;
          SEL_CNT:  xfer_cnt  <= wr_data[CW-1:0];
          SEL_RLD:  reload    <= wr_data[CW-1:0];
          SEL_CHN:  chain_cnt <= wr_data[NW-1:0];
          default: ;
        endcase
      end
    end
  end

  a_r2_end_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && active && xfer_cnt == CW'(1) && end_by_tc && !wr_en) |=> end_flag);

  a_r4_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !wr_en && (dmode == 2'b00 || dmode == 2'b11)) |=> $stable(dst_addr));

  a_r5_single_dev: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !wr_en && single_dev) |=> $stable(dst_addr));

  a_r6_irq_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(end_flag) && irq_en) |-> irq);

  a_r7_clr_every: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && active && clr_sel && src == SRC_MOD) |-> flag_clr);

  a_r9_chain_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && active && xfer_cnt == CW'(1) && chain_en && chain_cnt != '0 && !wr_en)
      |=> (xfer_cnt == $past(reload)));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !(wr_en && wr_sel == SEL_CTRL && !wr_data[11])) |=> end_flag);

  a_r10_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag |-> !xfer_req);
endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, CW = 16, NW = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, mod_req = 0, ext_req = 0, xfer_done = 0;
  logic [2:0] wr_sel = 0;
  logic [AW-1:0] wr_data = 0;
  logic xfer_req, flag_clr, end_flag, irq;
  logic [AW-1:0] dst_addr;
  logic [CW-1:0] xfer_cnt;
  logic [NW-1:0] chain_cnt;

  int n_chk = 0, n_fail = 0;
  logic clr_seen;

  dma_chan_seq #(.AW(AW), .CW(CW), .NW(NW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mod_req(mod_req), .ext_req(ext_req), .xfer_done(xfer_done),
    .xfer_req(xfer_req), .flag_clr(flag_clr), .dst_addr(dst_addr),
    .xfer_cnt(xfer_cnt), .chain_cnt(chain_cnt), .end_flag(end_flag), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // ctrl, start addr, count, completions, expected addr, expected end
  localparam logic [31:0] VEC [7][6] = '{
    '{32'h202, 32'h100, 3, 3, 32'h103, 1},
    '{32'h20A, 32'h100, 4, 2, 32'h104, 0},
    '{32'h214, 32'h100, 2, 2, 32'h0F8, 1},
    '{32'h216, 32'h100, 2, 2, 32'h100, 1},
    '{32'h612, 32'h100, 2, 2, 32'h100, 1},
    '{32'h200, 32'h100, 1, 1, 32'h100, 1},
    '{32'h204, 32'h000, 1, 1, 32'hFFFFFFFF, 1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); xfer_done = 1; #1 clr_seen = flag_clr;
    @(negedge clk); xfer_done = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2) rst_n = 1;
    @(negedge clk);
    check("R1 cnt", xfer_cnt, 0); check("R1 chain", chain_cnt, 0);
    check("R1 addr", dst_addr, 0); check("R1 end", end_flag, 0);
    check("R1 req", xfer_req, 0); check("R1 clr", flag_clr, 0); check("R1 irq", irq, 0);

    for (int i = 0; i < 7; i++) begin
      wr(0, VEC[i][0]); wr(1, VEC[i][1]); wr(2, VEC[i][2]);
      for (int k = 0; k < int'(VEC[i][3]); k++) pulse();
      check("R4 R5 vector addr", dst_addr, VEC[i][4]);
      check("R2 vector end", end_flag, VEC[i][5]);
    end

    // R7: on-chip, clear only at count end
    wr(0, 32'h20); mod_req = 1; wr(2, 3);
    check("R11 onchip req", xfer_req, 1);
    pulse(); check("R7 clr mid", clr_seen, 0);
    pulse(); check("R7 clr mid", clr_seen, 0);
    pulse(); check("R7 clr last", clr_seen, 1);
    check("R2 end", end_flag, 1); check("R10 req low", xfer_req, 0);
    check("R6 irq off", irq, 0);

    // R7 every transfer, R6 irq, R10 sticky
    wr(0, 32'h61); wr(2, 2);
    pulse(); check("R7 clr every", clr_seen, 1);
    pulse(); check("R7 clr every", clr_seen, 1);
    check("R6 irq on", irq, 1);
    wr(2, 1); pulse();
    check("R10 blocked cnt", xfer_cnt, 1); check("R10 blocked clr", clr_seen, 0);
    wr(0, 32'h861); check("R10 write one keeps", end_flag, 1);
    wr(0, 32'h061); check("R10 clear", end_flag, 0); check("R6 irq off", irq, 0);
    mod_req = 0; @(negedge clk); check("R11 no mod req", xfer_req, 0);
    mod_req = 1;

    // R9 / R3 chain, end after all chains
    wr(0, 32'h80); wr(3, 2); wr(4, 1); wr(2, 2);
    pulse(); pulse();
    check("R9 reload", xfer_cnt, 2); check("R9 chain dec", chain_cnt, 0);
    check("R3 no end yet", end_flag, 0);
    pulse(); pulse();
    check("R3 end after chains", end_flag, 1); check("R3 cnt", xfer_cnt, 0);

    // R2 end_sel=1 with chain
    wr(0, 32'hA0); wr(3, 1); wr(4, 1); wr(2, 1);
    pulse();
    check("R2 end each block", end_flag, 1); check("R9 reload2", xfer_cnt, 1);
    wr(0, 32'hA0); pulse();
    check("R2 end final", end_flag, 1); check("R2 cnt", xfer_cnt, 0);

    // R2 auto overrides end_sel
    wr(0, 32'h280); wr(3, 1); wr(4, 1); wr(2, 1);
    pulse(); check("R2 auto end", end_flag, 1);

    // R3 chain disabled
    wr(0, 32'h0); wr(4, 0); wr(2, 1); pulse();
    check("R3 nochain end", end_flag, 1);
    wr(0, 32'h0); wr(4, 2); wr(2, 1); pulse();
    check("R3 stuck no end", end_flag, 0); check("R3 cnt zero", xfer_cnt, 0);
    check("R11 idle req", xfer_req, 0);
    mod_req = 0;

    // R8 external edge
    wr(4, 0); wr(0, 32'h160); wr(2, 3);
    check("R8 no edge", xfer_req, 0);
    @(negedge clk); ext_req = 1;
    @(negedge clk); check("R8 edge latched", xfer_req, 1);
    pulse(); check("R8 cleared each", xfer_req, 0);
    check("R7 ext no clr", clr_seen, 0);
    wr(0, 32'h120); ext_req = 0;
    @(negedge clk); ext_req = 1;
    @(negedge clk); check("R8 edge2", xfer_req, 1);
    pulse(); check("R8 held", xfer_req, 1);
    pulse(); check("R8 end", end_flag, 1); check("R8 req off", xfer_req, 0);

    // R12 write beats completion
    wr(0, 32'h202); wr(1, 32'h40); wr(2, 5);
    @(negedge clk); xfer_done = 1; wr_en = 1; wr_sel = 1; wr_data = 32'h80;
    @(negedge clk); xfer_done = 0; wr_en = 0;
    check("R12 write wins", dst_addr, 32'h80); check("R12 cnt", xfer_cnt, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule